// File: doc/BRIEF.md
# Multi-mode programmable decade down-divider

This block divides its clock by a programmable count n. It counts down from a preset value, reloads the preset at the end of each period, and marks that moment on its output. The count is held in four first-stage flip-flops and three 4-bit decades. A mode input decides how many of the four first-stage bits form a low-order prescaler (modulus 10, 8, 5, 4 or 2). The first-stage bits that the prescaler does not use become a small thousands stage. The period is n = MOD × (1000·T + 100·D4 + 10·D3 + D2) + P. Here P is the prescaler preset and T is the thousands preset.

The hold input selects the output style. With hold low, the output gives one pulse one clock wide per period. With hold high, the output latches at the first pulse and stays high while counting goes on, which is the timer behaviour. Three more behaviours complete the block:
- A master-preset mode that loads the preset and holds it.
- One arming edge after master preset or reset.
- A fixed divide-by-10000 mode that ignores the preset.

Top module: `decade_prog_divider`

## Requirements
- R1: `preset[3:0]` is the first-stage field, `preset[7:4]` is D2, `preset[11:8]` is D3 and `preset[15:12]` is D4. With `mode_sel` 3'b011 the prescaler uses all four first-stage bits with modulus 10, and there is no thousands stage. Output pulses repeat every n = 10·(100·D4 + 10·D3 + D2) + P clocks.
- R2: Each mode splits the first stage as follows, with n given by the formula above:

| `mode_sel` | Modulus | Prescaler bits | Thousands bits |
|---|---|---|---|
| 3'b010 or 3'b110 | 8 | [2:0] | [3] |
| 3'b100 | 5 | [2:0] | [3] |
| 3'b101 | 4 | [1:0] | [3:2] |
| 3'b111 | 2 | [0] | [3:1] |

- R3: With `hold_en` low, `q` is high for exactly one clock per period.
- R4: With `hold_en` high in a mode other than 3'b000 and 3'b001, `q` stays high after its first pulse. It clears at the first rising edge at which `hold_en` is low. Counting continues while `q` is held, so the following pulse keeps its place in the period sequence.
- R5: While `mode_sel` is 3'b001 (master preset), the counter loads the preset at every edge and `q` is low.
- R6: After reset or master preset, the first rising edge in a counting mode only arms the counter. The first pulse is therefore high after edge number n counted from that arming edge (edge 0), one count later than a steady period.
- R7: With `mode_sel` 3'b000 and `hold_en` low, every period after the first lasts 10000 clocks whatever the preset. The first period after arming is still set by the preset with modulus 10.
- R8: With `mode_sel` 3'b000 and `hold_en` high, the block divides by the preset-based n with modulus 10, and `q` stays a one-clock pulse.
- R9: A decade preset from 10 to 15 counts its binary value during the period in which it is loaded and keeps its place value 1, 10 or 100.
- R10: During reset `q` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode and prescaler selection |
| hold_en | input | 1 | Output latch enable (timer behaviour) |
| preset | input | 16 | Preset: first-stage field and three decades |
| q | output | 1 | Divided output, pulse or latched level |

## Verification
The embedded properties check these rules on every cycle:
- `q` stays low in master preset and while the counter is unarmed.
- The counter holds the preset through master preset.
- A non-latching pulse never lasts two cycles.
- A latched output stays high while hold is asserted.
- The fixed reload value is taken in divide-by-10000.

Period lengths, the extra arming count, the mode-dependent split of the first-stage bits and the effect of decades preset above 9 all span thousands of cycles. Only the bench's measured periods can show them.

// File: rtl/decade_prog_divider.sv
module decade_prog_divider #(
  parameter int DW = 4,
  parameter int NDEC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode_sel,
  input  logic                     hold_en,
  input  logic [DW*(NDEC+1)-1:0]   preset,
  output logic                     q
);
  localparam int CW = DW*(NDEC+1);
  localparam logic [CW-1:0] FIXED_RELOAD = CW'(10) << (DW*NDEC);

  logic [CW-1:0] cnt, cnt_dec, reload;
  logic          armed, qr;
  logic [DW-1:0] modv, pmask, pre, th, pre_n, th_n;
  logic [2:0]    pw;
  logic [NDEC:0] brw;
  logic          term, mp, inhibit, latch_en;

  assign mp       = (mode_sel == 3'b001);
  assign inhibit  = (mode_sel == 3'b000) && !hold_en;
  assign latch_en = hold_en && (mode_sel != 3'b000) && !mp;
  assign reload   = inhibit ? FIXED_RELOAD : preset;
  assign q        = qr;

  always_comb begin
    case (mode_sel)
      3'b010, 3'b110: begin modv = DW'(8); pw = 3'd3; end
      3'b100:         begin modv = DW'(5); pw = 3'd3; end
      3'b101:         begin modv = DW'(4); pw = 3'd2; end
      3'b111:         begin modv = DW'(2); pw = 3'd1; end
      default:        begin modv = DW'(10); pw = 3'd4; end
    endcase
    pmask  = DW'((5'd1 << pw) - 5'd1);
    pre    = cnt[DW-1:0] & pmask;
    th     = cnt[DW-1:0] >> pw;
    brw[0] = (pre == '0);
    pre_n  = brw[0] ? modv - DW'(1) : pre - DW'(1);
    cnt_dec = cnt;
    for (int i = 1; i <= NDEC; i++) begin
      brw[i] = brw[i-1] && (cnt[i*DW +: DW] == '0);
      if (brw[i-1])
        cnt_dec[i*DW +: DW] = (cnt[i*DW +: DW] == '0) ? DW'(9) : cnt[i*DW +: DW] - DW'(1);
    end
    th_n = brw[NDEC] ? th - DW'(1) : th;
    cnt_dec[DW-1:0] = DW'(th_n << pw) | pre_n;
    term = (pre == DW'(1)) && (th == '0) && (cnt[CW-1:DW] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      qr    <= 1'b0;
    end else if (mp) begin
      cnt   <= preset;
      armed <= 1'b0;
      qr    <= 1'b0;
    end else if (!armed) begin
      cnt   <= preset;
      armed <= 1'b1;
      qr    <= 1'b0;
    end else if (term) begin
      cnt   <= reload;
      qr    <= 1'b1;
    end else begin
      cnt   <= cnt_dec;
      qr    <= qr && latch_en;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !latch_en) |=> !q); // R3
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (q && latch_en) |=> q); // R4
  AST_MP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mp |=> !q); // R5
  AST_MP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mp |=> (cnt == $past(preset))); // R5
  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !q); // R6
  AST_FIXED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && term && inhibit && !mp) |=> (cnt == FIXED_RELOAD)); // R7
endmodule

// File: tb/tb_decade_prog_divider.sv
module tb_decade_prog_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'b011;
  logic        hold_en = 1'b0;
  logic [15:0] preset = 16'h0000;
  logic        q;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  decade_prog_divider dut (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .hold_en(hold_en), .preset(preset), .q(q));

  // {mode_sel, hold_en, preset}
  localparam logic [19:0] VEC [8] = '{
    {3'b011, 1'b0, 16'h0123},
    {3'b010, 1'b0, 16'h0156},
    {3'b111, 1'b0, 16'h0003},
    {3'b100, 1'b0, 16'h0234},
    {3'b101, 1'b0, 16'h0007},
    {3'b011, 1'b0, 16'h00F5},
    {3'b000, 1'b1, 16'h0123},
    {3'b110, 1'b0, 16'h00A6}
  };

  function automatic int calc_n(logic [2:0] s, logic [15:0] p);
    int dv, pw, lo, th;
    case (s)
      3'b010, 3'b110: begin dv = 8; pw = 3; end
      3'b100:         begin dv = 5; pw = 3; end
      3'b101:         begin dv = 4; pw = 2; end
      3'b111:         begin dv = 2; pw = 1; end
      default:        begin dv = 10; pw = 4; end
    endcase
    lo = int'(p[3:0]) & ((1 << pw) - 1);
    th = int'(p[3:0]) >> pw;
    return dv * (1000*th + 100*int'(p[15:12]) + 10*int'(p[11:8]) + int'(p[7:4])) + lo;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] s, logic h, logic [15:0] p);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = s; hold_en = h; preset = p;
    @(negedge clk);
    check(q == 1'b0, "R10 reset q", int'(q), 0);
    rst_n = 1'b1;
  endtask

  // counts negedges until q is high; first pulse expected at index T+1 (R6)
  task automatic first_pulse(int t, string req);
    int k = 0;
    do begin @(negedge clk); k++; end while (!q && k < 30000);
    check(k == t + 1, req, k, t + 1);
  endtask

  task automatic next_period(int n, string req);
    int m = 1;
    @(negedge clk);
    check(q == 1'b0, {req, " pulse width"}, int'(q), 0);
    while (!q && m < 30000) begin @(negedge clk); m++; end
    check(m == n, req, m, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // R1 R2 R3 R6 R8 R9: vector table
    for (int i = 0; i < 8; i++) begin
      do_reset(VEC[i][19:17], VEC[i][16], VEC[i][15:0]);
      n = calc_n(VEC[i][19:17], VEC[i][15:0]);
      first_pulse(n, "R6 first pulse after arming");
      next_period(n, "R1 R2 R8 R9 period");
    end

    // R7: fixed 10000 divider, first period from preset, preset ignored afterwards
    do_reset(3'b000, 1'b0, 16'h0123);
    first_pulse(123, "R7 first period from preset");
    next_period(10000, "R7 fixed period");
    preset = 16'h0999;
    next_period(10000, "R7 preset ignored");

    // R4: timer latch
    do_reset(3'b011, 1'b1, 16'h0123);
    first_pulse(123, "R4 timer first pulse");
    begin
      bit held = 1'b1;
      int m = 0;
      for (int j = 0; j < 50; j++) begin @(negedge clk); if (!q) held = 1'b0; end
      check(held, "R4 output held high", int'(held), 1);
      hold_en = 1'b0;
      @(negedge clk);
      check(q == 1'b0, "R4 released by hold low", int'(q), 0);
      m = 51;
      while (!q && m < 30000) begin @(negedge clk); m++; end
      check(m == 123, "R4 counting continued while held", m, 123);
    end

    // R5: master preset holds and silences output, R6: arming after it
    @(negedge clk);
    mode_sel = 3'b001; preset = 16'h0234;
    begin
      bit quiet = 1'b1;
      for (int j = 0; j < 300; j++) begin @(negedge clk); if (q) quiet = 1'b0; end
      check(quiet, "R5 q low in master preset", int'(quiet), 1);
    end
    mode_sel = 3'b100;
    first_pulse(119, "R6 first pulse after master preset");
    next_period(119, "R5 preset held then counted");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule